// File: doc/BRIEF.md
# Multiplexed Address/Data Master Port

This block sits between a master processor and a shared byte-wide memory core. The master drives a single bus that carries an address in one phase and a data byte in a later phase. Three active-low phase qualifiers (frame, initiator-ready and target-ready) mark which phase is present on the bus. The block sorts each sampled bus value into an address phase, a data phase or neither, and keeps the address and the write byte in registers.

When the master pulls its enable low, the block starts a single-byte transfer to the memory core. It does so only while the arbiter grant (an active-low busy line) is held and the needed bytes have been latched. The transfer is a write when the write strobe is low and a read when it is high. For a read, the block returns the fetched byte on its read-data output. It signals completion by pulling an active-low acknowledge, which it holds until the master releases the enable. Each completed transfer discards the latched address and data, so every transfer needs a fresh address phase.

The memory core is synchronous: a request strobed in one cycle performs its write, or returns its read byte, at the next rising edge.

Top module: `muxbus_master_port`

## Requirements
- R1: After reset the acknowledge is high, the read-data output is zero and no memory request is issued.
- R2: A rising edge that samples frame low with initiator-ready and target-ready both high stores the bus value as the transfer address. This address appears on the memory address output when the access is issued.
- R3: A rising edge that samples frame high with initiator-ready and target-ready both low stores the bus value as the write byte, provided an address is already held. A write that is requested before its data phase waits and proceeds once the data phase arrives.
- R4: A data phase sampled while no address is held stores nothing. A following write request then issues no memory access and gets no acknowledge.
- R5: A write request (enable low, write strobe low, grant held, address and data held) issues exactly one memory request cycle with the write flag high, carrying the held address and byte. A write leaves the read-data output unchanged.
- R6: A read request (enable low, write strobe high, grant held, address held) issues exactly one memory request cycle with the write flag low. The byte the memory returns is on the read-data output by the time the acknowledge goes low.
- R7: While the busy line is high, no memory request is issued and no acknowledge is given. The pending transfer proceeds once the busy line goes low.
- R8: Counting rising edges from the one that first samples an acceptable request, the acknowledge goes low after the third edge. It stays low while the enable is held low and returns high on the first edge that samples the enable high.
- R9: A completed transfer clears the held address and data, so a request with no new address phase issues no memory access.
- R10: Any other combination of the three phase qualifiers, such as all three low, stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | AD_W | Shared address/data bus from the master |
| frame_n_i | input | 1 | Frame qualifier, active low |
| irdy_n_i | input | 1 | Initiator-ready qualifier, active low |
| trdy_n_i | input | 1 | Target-ready qualifier, active low |
| wr_n_i | input | 1 | Write strobe, low selects write, high selects read |
| en_n_i | input | 1 | Transfer enable, active low |
| busy_n_i | input | 1 | Arbiter grant for the master, low when granted |
| mem_en_o | output | 1 | Memory request strobe, one cycle per transfer |
| mem_we_o | output | 1 | Memory write flag, valid with the strobe |
| mem_addr_o | output | AD_W | Memory address |
| mem_wdata_o | output | AD_W | Memory write byte |
| mem_rdata_i | input | AD_W | Memory read byte, valid the cycle after the strobe |
| rdata_o | output | AD_W | Read byte returned to the master |
| ack_n_o | output | 1 | Data acknowledge, active low |

## Verification
A wrong phase decode or a stale latch shows up on the memory address and write-byte outputs during the one request cycle, which comes two edges after the enable is seen. A sequencer stuck in the wrong state shows up as a missing, early or doubled request strobe, or as an acknowledge that is mistimed against the third-edge rule. A failure to clear the held bytes after a transfer shows up as an extra memory request when the master asks again without a new address phase. A grant that is ignored shows up as a request strobe while the busy line is high.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } bus_phase_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DONE    = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/muxbus_phase_decode.sv
module muxbus_phase_decode
    import muxbus_pkg::*;
(
    input  logic       frame_n_i,
    input  logic       irdy_n_i,
    input  logic       trdy_n_i,
    output bus_phase_e phase_o
);

    always_comb begin
        phase_o = PH_NONE;
        unique case ({frame_n_i, irdy_n_i, trdy_n_i})
            3'b011:  phase_o = PH_ADDR;
            3'b100:  phase_o = PH_DATA;
            default: phase_o = PH_NONE;
        endcase
    end

endmodule

// File: rtl/muxbus_xfer_ctrl.sv
module muxbus_xfer_ctrl
    import muxbus_pkg::*;
#(
    parameter int AD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bus_phase_e      phase_i,
    input  logic [AD_W-1:0] ad_i,
    input  logic            wr_n_i,
    input  logic            en_n_i,
    input  logic            busy_n_i,
    output logic            mem_en_o,
    output logic            mem_we_o,
    output logic [AD_W-1:0] mem_addr_o,
    output logic [AD_W-1:0] mem_wdata_o,
    input  logic [AD_W-1:0] mem_rdata_i,
    output logic [AD_W-1:0] rdata_o,
    output logic            ack_n_o
);

    typedef struct packed {
        xfer_state_e     st;
        logic [AD_W-1:0] addr;
        logic [AD_W-1:0] wdata;
        logic            addr_vld;
        logic            data_vld;
        logic            we;
        logic [AD_W-1:0] rdata;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic       go;

    always_comb begin
        r_d = r_q;
        go  = !en_n_i && !busy_n_i && r_q.addr_vld && (wr_n_i || r_q.data_vld);
        unique case (r_q.st)
            ST_IDLE: begin
                if (go) begin
                    r_d.st = ST_ACCESS;
                    r_d.we = !wr_n_i;
                end else if (phase_i == PH_ADDR) begin
                    r_d.addr     = ad_i;
                    r_d.addr_vld = 1'b1;
                    r_d.data_vld = 1'b0;
                end else if (phase_i == PH_DATA && r_q.addr_vld) begin
                    r_d.wdata    = ad_i;
                    r_d.data_vld = 1'b1;
                end
            end
            ST_ACCESS: begin
                r_d.st = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (!r_q.we) begin
                    r_d.rdata = mem_rdata_i;
                end
                r_d.st = ST_DONE;
            end
            ST_DONE: begin
                if (en_n_i) begin
                    r_d.st       = ST_IDLE;
                    r_d.addr_vld = 1'b0;
                    r_d.data_vld = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_en_o    = (r_q.st == ST_ACCESS);
    assign mem_we_o    = mem_en_o && r_q.we;
    assign mem_addr_o  = r_q.addr;
    assign mem_wdata_o = r_q.wdata;
    assign rdata_o     = r_q.rdata;
    assign ack_n_o     = (r_q.st != ST_DONE);

endmodule

// File: rtl/muxbus_master_port.sv
module muxbus_master_port
    import muxbus_pkg::*;
#(
    parameter int AD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_i,
    input  logic            frame_n_i,
    input  logic            irdy_n_i,
    input  logic            trdy_n_i,
    input  logic            wr_n_i,
    input  logic            en_n_i,
    input  logic            busy_n_i,
    output logic            mem_en_o,
    output logic            mem_we_o,
    output logic [AD_W-1:0] mem_addr_o,
    output logic [AD_W-1:0] mem_wdata_o,
    input  logic [AD_W-1:0] mem_rdata_i,
    output logic [AD_W-1:0] rdata_o,
    output logic            ack_n_o
);

    bus_phase_e phase;

    muxbus_phase_decode u_phase (
        .frame_n_i (frame_n_i),
        .irdy_n_i  (irdy_n_i),
        .trdy_n_i  (trdy_n_i),
        .phase_o   (phase)
    );

    muxbus_xfer_ctrl #(.AD_W(AD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .ad_i        (ad_i),
        .wr_n_i      (wr_n_i),
        .en_n_i      (en_n_i),
        .busy_n_i    (busy_n_i),
        .mem_en_o    (mem_en_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .rdata_o     (rdata_o),
        .ack_n_o     (ack_n_o)
    );

endmodule

// File: rtl/muxbus_master_port_chk.sv
module muxbus_master_port_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_n_i,
    input logic en_n_i,
    input logic busy_n_i,
    input logic mem_en_o,
    input logic mem_we_o,
    input logic ack_n_o
);

    assert_grant_before_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en_o) |-> ($past(busy_n_i) == 1'b0));

    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |=> !mem_en_o);

    assert_write_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o && mem_we_o) |-> ($past(wr_n_i) == 1'b0));

    assert_read_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o && !mem_we_o) |-> ($past(wr_n_i) == 1'b1));

    assert_ack_after_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_o) |-> $past(mem_en_o, 2));

    assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n_o && en_n_i) |=> ack_n_o);

    assert_no_access_while_acked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> ack_n_o);

endmodule

bind muxbus_master_port muxbus_master_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_n_i   (wr_n_i),
    .en_n_i   (en_n_i),
    .busy_n_i (busy_n_i),
    .mem_en_o (mem_en_o),
    .mem_we_o (mem_we_o),
    .ack_n_o  (ack_n_o)
);

// File: tb/muxbus_master_port_tb.sv
`timescale 1ns/1ps
module muxbus_master_port_tb;

    localparam int AD_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AD_W-1:0] ad = '0;
    logic            frame_n = 1'b1;
    logic            irdy_n = 1'b1;
    logic            trdy_n = 1'b1;
    logic            wr_n = 1'b1;
    logic            en_n = 1'b1;
    logic            busy_n = 1'b0;
    logic            mem_en;
    logic            mem_we;
    logic [AD_W-1:0] mem_addr;
    logic [AD_W-1:0] mem_wdata;
    logic [AD_W-1:0] mem_rdata = '0;
    logic [AD_W-1:0] rdata;
    logic            ack_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [AD_W-1:0] mem [256];
    int              acc_cnt = 0;
    logic            last_we = 1'b0;
    logic [AD_W-1:0] last_addr = '0;
    logic [AD_W-1:0] last_wdata = '0;

    always #5 clk = ~clk;

    muxbus_master_port #(.AD_W(AD_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ad_i        (ad),
        .frame_n_i   (frame_n),
        .irdy_n_i    (irdy_n),
        .trdy_n_i    (trdy_n),
        .wr_n_i      (wr_n),
        .en_n_i      (en_n),
        .busy_n_i    (busy_n),
        .mem_en_o    (mem_en),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .rdata_o     (rdata),
        .ack_n_o     (ack_n)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            acc_cnt    <= acc_cnt + 1;
            last_we    <= mem_we;
            last_addr  <= mem_addr;
            last_wdata <= mem_wdata;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input logic [AD_W-1:0] a);
        @(negedge clk);
        ad = a; frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
        @(negedge clk);
        frame_n = 1'b1;
    endtask

    task automatic data_phase(input logic [AD_W-1:0] d);
        @(negedge clk);
        ad = d; frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
        @(negedge clk);
        irdy_n = 1'b1; trdy_n = 1'b1;
    endtask

    task automatic wait_ack(input int max_cyc, output bit got);
        got = 1'b0;
        for (int i = 0; i < max_cyc && !got; i++) begin
            @(negedge clk);
            if (!ack_n) got = 1'b1;
        end
    endtask

    task automatic release_en();
        @(negedge clk);
        en_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(ack_n === 1'b1, "R1 ack", ack_n, 1);
        check(rdata === '0, "R1 rdata", rdata, 0);
        check(mem_en === 1'b0, "R1 mem_en", mem_en, 0);
    endtask

    task automatic t_write_timing();
        int c0;
        logic [AD_W-1:0] r0;
        c0 = acc_cnt; r0 = rdata;
        addr_phase(8'h3C);
        data_phase(8'hA7);
        @(negedge clk);
        wr_n = 1'b0; en_n = 1'b0;
        @(negedge clk);
        check(ack_n === 1'b1, "R8 ack high after edge 1", ack_n, 1);
        @(negedge clk);
        check(ack_n === 1'b1, "R8 ack high after edge 2", ack_n, 1);
        @(negedge clk);
        check(ack_n === 1'b0, "R8 ack low after edge 3", ack_n, 0);
        check(acc_cnt == c0 + 1, "R5 one access", acc_cnt - c0, 1);
        check(last_we === 1'b1, "R5 write flag", last_we, 1);
        check(last_addr === 8'h3C, "R2 address", last_addr, 8'h3C);
        check(last_wdata === 8'hA7, "R3 write byte", last_wdata, 8'hA7);
        check(mem[8'h3C] === 8'hA7, "R5 memory", mem[8'h3C], 8'hA7);
        check(rdata === r0, "R5 rdata unchanged", rdata, r0);
        repeat (3) @(negedge clk);
        check(ack_n === 1'b0, "R8 ack held while enabled", ack_n, 0);
        @(negedge clk);
        en_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        check(ack_n === 1'b1, "R8 ack released", ack_n, 1);
    endtask

    task automatic t_read(input logic [AD_W-1:0] a, input logic [AD_W-1:0] exp);
        int c0;
        bit got;
        c0 = acc_cnt;
        addr_phase(a);
        @(negedge clk);
        wr_n = 1'b1; en_n = 1'b0;
        wait_ack(10, got);
        check(got, "R6 read ack", got, 1);
        check(rdata === exp, "R6 read byte", rdata, exp);
        check(acc_cnt == c0 + 1 && last_we === 1'b0, "R6 one read access", acc_cnt - c0, 1);
        release_en();
    endtask

    task automatic t_no_access(input string req, input bit wr);
        int c0;
        bit got;
        c0 = acc_cnt;
        @(negedge clk);
        wr_n = !wr; en_n = 1'b0;
        wait_ack(8, got);
        check(!got, req, got, 0);
        check(acc_cnt == c0, req, acc_cnt - c0, 0);
        release_en();
    endtask

    task automatic t_orphan_data();
        data_phase(8'h55);
        t_no_access("R4 data without address", 1'b1);
    endtask

    task automatic t_cleared();
        t_no_access("R9 no reuse after transfer", 1'b0);
    endtask

    task automatic t_bad_phase();
        @(negedge clk);
        ad = 8'h77; frame_n = 1'b0; irdy_n = 1'b0; trdy_n = 1'b0;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
        t_no_access("R10 illegal qualifiers", 1'b0);
    endtask

    task automatic t_grant();
        int c0;
        bit got;
        c0 = acc_cnt;
        addr_phase(8'h20);
        @(negedge clk);
        busy_n = 1'b1; wr_n = 1'b1; en_n = 1'b0;
        wait_ack(6, got);
        check(!got && acc_cnt == c0, "R7 held off without grant", acc_cnt - c0, 0);
        @(negedge clk);
        busy_n = 1'b0;
        wait_ack(10, got);
        check(got, "R7 proceeds after grant", got, 1);
        check(rdata === (8'h20 ^ 8'h5A), "R7 read after grant", rdata, 8'h20 ^ 8'h5A);
        release_en();
    endtask

    task automatic t_late_data();
        int c0;
        bit got;
        c0 = acc_cnt;
        addr_phase(8'h81);
        @(negedge clk);
        wr_n = 1'b0; en_n = 1'b0;
        wait_ack(5, got);
        check(!got && acc_cnt == c0, "R3 write waits for data", acc_cnt - c0, 0);
        @(negedge clk);
        ad = 8'hC3; irdy_n = 1'b0; trdy_n = 1'b0;
        @(negedge clk);
        irdy_n = 1'b1; trdy_n = 1'b1;
        wait_ack(10, got);
        check(got, "R3 write after late data", got, 1);
        check(last_addr === 8'h81 && last_wdata === 8'hC3, "R3 late data byte", last_wdata, 8'hC3);
        release_en();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_orphan_data();
        t_write_timing();
        t_read(8'h3C, 8'hA7);
        t_cleared();
        t_read(8'h10, 8'h10 ^ 8'h5A);
        t_bad_phase();
        t_grant();
        t_late_data();
        t_read(8'h81, 8'hC3);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule